// File: doc/BRIEF.md
# Byte-Wide Flash Bus Write-Side Emulator

This block stands in for a byte-wide, sector-erasable flash memory on an asynchronous strobe bus, running entirely off a fast system clock. The host drives active-low chip-select, write-strobe and output-enable lines together with a 19-bit address and an 8-bit data bus. All bus inputs pass through a synchronizer, and the block rebuilds the bus cycles from edges seen in the clock domain. A write cycle takes its address when the later of chip-select and write-strobe falls, and takes its data when the earlier of the two rises. A read cycle takes its address, for the protection tracker, when the earlier of chip-select and output-enable rises.

Program and erase commands are two-write sequences. Each starts a timed busy phase. During that phase reads return a status byte: bit 6 flips on every read, and bit 7 holds the complement of bit 7 of the data being written. Two fixed sequences of seven reads switch a software write lock on and off. The array is a small register bank sized by a parameter, and it reads 0xFF when erased. The bus is a plain strobe interface with no valid/ready pair and no back-pressure. The host must hold every strobe level and every address/data value for at least the synchronizer depth plus two clock cycles. Completion is found only by polling.

Top module: `flash_bus_emu`

## Requirements
- R1: After reset every byte reads 0xFF, the lock is off and no operation is busy. `dq_oe` is high only while chip-select and output-enable are low and write-strobe is high.
- R2: A write takes its address at the moment the second of `ce_n`/`we_n` goes low. Later address changes in the same cycle have no effect.
- R3: A write takes its data at the moment the first of `ce_n`/`we_n` goes high. The value present then is the one used.
- R4: Writing 0x10 arms a program, and the next write ANDs its data into the byte at its address. Writing 0x20 and then 0xD0 at any address erases that address's 256-byte sector to 0xFF. Any other first byte, or any confirm byte other than 0xD0, is dropped and leaves the array unchanged.
- R5: A program stays busy for `PROG_CYCLES` clock cycles and an erase for `ERASE_CYCLES`. Afterwards, reads return array data.
- R6: While busy, bit 6 of successive reads alternates. Once the operation ends, bit 6 of successive reads stops changing.
- R7: While busy, bit 7 of a read is the inverse of bit 7 of the byte being written (0x00 for an erase, since erase writes 0xFF). After completion, reads return the stored byte.
- R8: Writes that arrive during a busy phase, command bytes included, are ignored.
- R9: Reads from 0x00111, 0x00222, 0x00333, 0x00444, 0x00555, 0x00666, 0x00777 in that order set the lock. The same first six reads followed by 0x00888 clear it. While the lock is set, the program data write and the erase confirm are dropped and the block returns to idle without going busy.
- R10: A read from an address that is not the next step of a sequence sends that sequence's tracker back to its first step.
- R11: Address bits [8+k-1:8] (with k = log2(`ARRAY_BYTES`/256)) select the erase sector, and other sectors are untouched. Address bits at and above log2(`ARRAY_BYTES`) are ignored, so higher addresses alias onto the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip select, active low, asynchronous |
| we_n | input | 1 | Write strobe, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| addr | input | 19 | Byte address |
| dq_in | input | 8 | Data from host during writes |
| dq_out | output | 8 | Array data, or status byte while busy |
| dq_oe | output | 1 | High while a read cycle drives `dq_out` |

## Verification
A wrong command state shows up on the very next read. A stray busy phase returns a status byte in place of the array contents, and a missing busy phase returns plain data where the complemented bit 7 was expected. A wrong busy timer shows up within one program or erase time, as status seen after the window closes or data seen before it. A miscounted protection tracker is hidden until the next program attempt, which then sticks or fails to stick. Edge-combining faults show up as a byte stored at the wrong address or with the wrong value, and this appears on the read that follows the write.

// File: rtl/flash_emu_pkg.sv
package flash_emu_pkg;
  localparam int ADDR_W     = 19;
  localparam int DATA_W     = 8;
  localparam int SEQ_LEN    = 7;
  localparam int SECTOR_LOG = 8;

  localparam logic [DATA_W-1:0] OP_PROGRAM       = 8'h10;
  localparam logic [DATA_W-1:0] OP_ERASE_SETUP   = 8'h20;
  localparam logic [DATA_W-1:0] OP_ERASE_CONFIRM = 8'hD0;

  typedef enum logic [1:0] {
    CS_IDLE,
    CS_PROG_ARM,
    CS_ERASE_ARM,
    CS_BUSY
  } cmd_state_e;
endpackage

// File: rtl/flash_bus_sync.sv
module flash_bus_sync #(
  parameter int             W      = 1,
  parameter int             STAGES = 2,
  parameter logic [W-1:0]   INIT   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stg[s] <= INIT;
          else        stg[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stg[s] <= INIT;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/flash_bus_edges.sv
module flash_bus_edges #(
  parameter int AW   = 19,
  parameter int DW   = 8,
  parameter int WA_W = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce_s,
  input  logic            we_s,
  input  logic            oe_s,
  input  logic [AW-1:0]   addr_s,
  input  logic [DW-1:0]   data_s,
  output logic            wr_stb,
  output logic [WA_W-1:0] wr_addr,
  output logic [DW-1:0]   wr_data,
  output logic            rd_active,
  output logic            rd_end,
  output logic [AW-1:0]   rd_end_addr
);
  logic wr_act, wr_act_q, rd_act_q;

  assign wr_act    = !ce_s && !we_s;
  assign rd_active = !ce_s && !oe_s && we_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_act_q    <= 1'b0;
      rd_act_q    <= 1'b0;
      wr_stb      <= 1'b0;
      wr_addr     <= '0;
      wr_data     <= '0;
      rd_end      <= 1'b0;
      rd_end_addr <= '0;
    end else begin
      wr_act_q <= wr_act;
      rd_act_q <= rd_active;
      wr_stb   <= 1'b0;
      rd_end   <= 1'b0;
      // later of the two falling edges opens the cycle: take address
      if (wr_act && !wr_act_q) wr_addr <= addr_s[WA_W-1:0];
      // earlier of the two rising edges closes it: take data
      if (!wr_act && wr_act_q) begin
        wr_stb  <= 1'b1;
        wr_data <= data_s;
      end
      // read closes on the first of OE/CE going high
      if (!rd_active && rd_act_q) begin
        rd_end      <= 1'b1;
        rd_end_addr <= addr_s;
      end
    end
  end

  assert_wr_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  assert_rd_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_end |=> !rd_end);
endmodule

// File: rtl/flash_seq_tracker.sv
module flash_seq_tracker #(
  parameter int                    AW  = 19,
  parameter int                    LEN = 7,
  parameter logic [LEN*AW-1:0]     SEQ = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_end,
  input  logic [AW-1:0] rd_addr,
  output logic          hit
);
  localparam int IX_W = $clog2(LEN);

  logic [IX_W-1:0] idx;
  logic [AW-1:0]   want;

  assign want = SEQ[idx*AW +: AW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0;
      hit <= 1'b0;
    end else begin
      hit <= 1'b0;
      if (rd_end) begin
        if (rd_addr == want) begin
          if (idx == IX_W'(LEN-1)) begin
            idx <= '0;
            hit <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end else begin
          idx <= '0;
        end
      end
    end
  end

  assert_step_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    idx < IX_W'(LEN));
  assert_hit_restarts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> idx == '0);
endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
  import flash_emu_pkg::*;
#(
  parameter int ARRAY_BYTES  = 512,
  parameter int PROG_CYCLES  = 8750,
  parameter int ERASE_CYCLES = 500000
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_stb,
  input  logic [$clog2(ARRAY_BYTES)-1:0] wr_addr,
  input  logic [DATA_W-1:0]              wr_data,
  input  logic                           rd_end,
  input  logic [$clog2(ARRAY_BYTES)-1:0] rd_idx,
  input  logic                           prot_on,
  input  logic                           prot_off,
  output logic [DATA_W-1:0]              dq_out
);
  localparam int IDX_W  = $clog2(ARRAY_BYTES);
  localparam int T_MAX  = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
  localparam int T_W    = $clog2(T_MAX + 1);

  cmd_state_e          state;
  logic [T_W-1:0]      timer;
  logic                is_erase;
  logic [IDX_W-1:0]    tgt_idx;
  logic [DATA_W-1:0]   tgt_data;
  logic                tog;
  logic                locked;
  logic [DATA_W-1:0]   mem [ARRAY_BYTES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= CS_IDLE;
      timer    <= '0;
      is_erase <= 1'b0;
      tgt_idx  <= '0;
      tgt_data <= '0;
      tog      <= 1'b0;
      locked   <= 1'b0;
      for (int j = 0; j < ARRAY_BYTES; j++) mem[j] <= '1;
    end else begin
      if (prot_on)  locked <= 1'b1;
      if (prot_off) locked <= 1'b0;
      if (rd_end && state == CS_BUSY) tog <= ~tog;
      unique case (state)
        CS_IDLE: begin
          if (wr_stb) begin
            if (wr_data == OP_PROGRAM)          state <= CS_PROG_ARM;
            else if (wr_data == OP_ERASE_SETUP) state <= CS_ERASE_ARM;
          end
        end
        CS_PROG_ARM: begin
          if (wr_stb) begin
            if (locked) begin
              state <= CS_IDLE;
            end else begin
              state    <= CS_BUSY;
              is_erase <= 1'b0;
              tgt_idx  <= wr_addr;
              tgt_data <= wr_data;
              timer    <= T_W'(PROG_CYCLES - 1);
            end
          end
        end
        CS_ERASE_ARM: begin
          if (wr_stb) begin
            if (wr_data == OP_ERASE_CONFIRM && !locked) begin
              state    <= CS_BUSY;
              is_erase <= 1'b1;
              tgt_idx  <= wr_addr;
              tgt_data <= '1;
              timer    <= T_W'(ERASE_CYCLES - 1);
            end else begin
              state <= CS_IDLE;
            end
          end
        end
        CS_BUSY: begin
          if (timer == '0) begin
            state <= CS_IDLE;
            if (is_erase) begin
              for (int j = 0; j < ARRAY_BYTES; j++)
                if ((j >> SECTOR_LOG) == int'(tgt_idx >> SECTOR_LOG)) mem[j] <= '1;
            end else begin
              mem[tgt_idx] <= mem[tgt_idx] & tgt_data;
            end
          end else begin
            timer <= timer - T_W'(1);
          end
        end
        default: state <= CS_IDLE;
      endcase
    end
  end

  assign dq_out = (state == CS_BUSY) ? {~tgt_data[DATA_W-1], tog, {(DATA_W-2){1'b0}}}
                                     : mem[rd_idx];

  assert_timer_descends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CS_BUSY && timer != '0) |=> (state == CS_BUSY && timer == $past(timer) - T_W'(1)));
  assert_busy_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CS_BUSY && wr_stb && timer != '0) |=> (state == CS_BUSY && $stable(tgt_data)));
  assert_toggle_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CS_BUSY && rd_end) |=> tog != $past(tog));
  assert_lock_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && wr_stb && state == CS_PROG_ARM) |=> state == CS_IDLE);
endmodule

// File: rtl/flash_bus_emu.sv
module flash_bus_emu
  import flash_emu_pkg::*;
#(
  parameter int ARRAY_BYTES  = 512,
  parameter int PROG_CYCLES  = 8750,
  parameter int ERASE_CYCLES = 500000,
  parameter int SYNC_STAGES  = 2,
  parameter logic [SEQ_LEN*ADDR_W-1:0] SEQ_ON = {
    19'h00777, 19'h00666, 19'h00555, 19'h00444, 19'h00333, 19'h00222, 19'h00111},
  parameter logic [SEQ_LEN*ADDR_W-1:0] SEQ_OFF = {
    19'h00888, 19'h00666, 19'h00555, 19'h00444, 19'h00333, 19'h00222, 19'h00111}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  localparam int IDX_W = $clog2(ARRAY_BYTES);
  localparam int BUS_W = ADDR_W + DATA_W;

  logic [2:0]        ctl_s;
  logic [BUS_W-1:0]  bus_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] data_s;

  flash_bus_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b111)) i_sync_ctl (
    .clk(clk), .rst_n(rst_n), .d({ce_n, we_n, oe_n}), .q(ctl_s));
  flash_bus_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .INIT('0)) i_sync_bus (
    .clk(clk), .rst_n(rst_n), .d({addr, dq_in}), .q(bus_s));

  assign {addr_s, data_s} = bus_s;

  logic              wr_stb, rd_end, rd_active;
  logic [IDX_W-1:0]  wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [ADDR_W-1:0] rd_end_addr;

  flash_bus_edges #(.AW(ADDR_W), .DW(DATA_W), .WA_W(IDX_W)) i_edges (
    .clk(clk), .rst_n(rst_n),
    .ce_s(ctl_s[2]), .we_s(ctl_s[1]), .oe_s(ctl_s[0]),
    .addr_s(addr_s), .data_s(data_s),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_active(rd_active), .rd_end(rd_end), .rd_end_addr(rd_end_addr));

  logic [1:0] seq_hit;

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_seq
      flash_seq_tracker #(.AW(ADDR_W), .LEN(SEQ_LEN),
                          .SEQ(g == 0 ? SEQ_ON : SEQ_OFF)) i_trk (
        .clk(clk), .rst_n(rst_n), .rd_end(rd_end),
        .rd_addr(rd_end_addr), .hit(seq_hit[g]));
    end
  endgenerate

  flash_cmd_engine #(.ARRAY_BYTES(ARRAY_BYTES), .PROG_CYCLES(PROG_CYCLES),
                     .ERASE_CYCLES(ERASE_CYCLES)) i_engine (
    .clk(clk), .rst_n(rst_n),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_end(rd_end), .rd_idx(addr_s[IDX_W-1:0]),
    .prot_on(seq_hit[0]), .prot_off(seq_hit[1]),
    .dq_out(dq_out));

  assign dq_oe = rd_active;

  assert_no_write_during_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !wr_stb);
endmodule

// File: tb/test_flash_bus_emu.sv
module test_flash_bus_emu;
  localparam int PROG  = 60;
  localparam int ERASE = 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [18:0] addr = '0;
  logic [7:0]  dq_in = '0;
  logic [7:0]  dq_out;
  logic        dq_oe;

  always #2 clk = ~clk;

  flash_bus_emu #(.PROG_CYCLES(PROG), .ERASE_CYCLES(ERASE)) i_flash_bus_emu (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe));

  typedef struct { logic [7:0] exp; logic [7:0] mask; string tag; } exp_t;
  exp_t sb_q[$];
  logic sample_req = 1'b0;
  int   errors = 0;
  int   checks = 0;
  bit   done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expectation per sample strobe
  always @(negedge clk) begin
    if (sample_req && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      chk(dq_oe === 1'b1 && (dq_out & e.mask) === (e.exp & e.mask), e.tag,
          {dq_oe, dq_out & e.mask}, {1'b1, e.exp & e.mask});
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_write(input logic [18:0] a, input logic [7:0] d, input bit ce_ctl,
                           input logic [18:0] a2, input logic [7:0] d2);
    addr = a; dq_in = d;
    if (ce_ctl) begin we_n = 1'b0; cyc(3); ce_n = 1'b0; end
    else        begin ce_n = 1'b0; cyc(3); we_n = 1'b0; end
    cyc(4);
    addr = a2; dq_in = d2;
    cyc(4);
    if (ce_ctl) begin ce_n = 1'b1; cyc(3); we_n = 1'b1; end
    else        begin we_n = 1'b1; cyc(3); ce_n = 1'b1; end
    cyc(3);
  endtask

  task automatic wr(input logic [18:0] a, input logic [7:0] d);
    bus_write(a, d, 1'b0, a, d);
  endtask

  task automatic rd_exp(input logic [18:0] a, input logic [7:0] e, input logic [7:0] m,
                        input string tag);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    cyc(5);
    sb_q.push_back('{exp: e, mask: m, tag: tag});
    sample_req = 1'b1;
    cyc(1);
    sample_req = 1'b0;
    oe_n = 1'b1; cyc(2); ce_n = 1'b1; cyc(4);
  endtask

  task automatic rd_raw(input logic [18:0] a, output logic [7:0] v);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    cyc(5);
    @(negedge clk) v = dq_out;
    cyc(1);
    oe_n = 1'b1; cyc(2); ce_n = 1'b1; cyc(4);
  endtask

  task automatic seq_reads(input bit off, input bit stray);
    logic [7:0] v;
    for (int i = 1; i <= 6; i++) rd_raw(19'(i * 'h111), v);
    if (stray) rd_raw(19'h01234, v);
    rd_raw(off ? 19'h00888 : 19'h00777, v);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [7:0] v1, v2;
    cyc(6);
    rst_n = 1'b1;
    cyc(4);
    // R1: reset state
    @(negedge clk) chk(dq_oe == 1'b0, "R1 dq_oe idle", dq_oe, 0);
    cyc(1);
    rd_exp(19'h00000, 8'hFF, 8'hFF, "R1 erased byte 0");
    rd_exp(19'h001FF, 8'hFF, 8'hFF, "R1 erased byte 1FF");

    // R4/R5/R6/R7: program, busy status, toggle
    wr(19'h00005, 8'h10);
    wr(19'h00005, 8'h3C);
    rd_exp(19'h00005, 8'h80, 8'h80, "R7 polling inverse bit7");
    rd_raw(19'h00005, v1);
    rd_raw(19'h00005, v2);
    chk(v1[6] != v2[6], "R6 toggle while busy", v2[6], ~v1[6]);
    cyc(40);
    rd_exp(19'h00005, 8'h3C, 8'hFF, "R5 R7 data after program");
    rd_raw(19'h00005, v1);
    rd_raw(19'h00005, v2);
    chk(v1 == v2 && v1 == 8'h3C, "R6 toggle stopped", v2, v1);

    // R4: program ANDs into the byte (CE-controlled)
    bus_write(19'h00005, 8'h10, 1'b1, 19'h00005, 8'h10);
    bus_write(19'h00005, 8'hF0, 1'b1, 19'h00005, 8'hF0);
    cyc(PROG + 10);
    rd_exp(19'h00005, 8'h30, 8'hFF, "R4 program ANDs");

    // R2/R3: CE-controlled with mid-cycle change
    bus_write(19'h00010, 8'h10, 1'b1, 19'h00010, 8'h10);
    bus_write(19'h00010, 8'hAA, 1'b1, 19'h00011, 8'h5A);
    cyc(PROG + 10);
    rd_exp(19'h00010, 8'h5A, 8'hFF, "R2 R3 ce-controlled");
    rd_exp(19'h00011, 8'hFF, 8'hFF, "R2 later address unused");
    // WE-controlled with mid-cycle change
    wr(19'h00012, 8'h10);
    bus_write(19'h00012, 8'h0F, 1'b0, 19'h00013, 8'hC3);
    cyc(PROG + 10);
    rd_exp(19'h00012, 8'hC3, 8'hFF, "R2 R3 we-controlled");
    rd_exp(19'h00013, 8'hFF, 8'hFF, "R2 we later address unused");

    // R8: writes during busy ignored
    wr(19'h00006, 8'h10);
    wr(19'h00006, 8'h00);
    wr(19'h00020, 8'h10);
    wr(19'h00020, 8'h00);
    cyc(PROG + 10);
    rd_exp(19'h00020, 8'hFF, 8'hFF, "R8 busy write dropped");
    rd_exp(19'h00006, 8'h00, 8'hFF, "R8 first program kept");

    // R4: unknown command and bad confirm
    wr(19'h00021, 8'h77);
    wr(19'h00021, 8'h00);
    rd_exp(19'h00021, 8'hFF, 8'hFF, "R4 unknown command");
    wr(19'h00005, 8'h20);
    wr(19'h00005, 8'h11);
    rd_exp(19'h00005, 8'h30, 8'hFF, "R4 bad confirm");

    // R11: erase sector 0 leaves sector 1
    wr(19'h00105, 8'h10);
    wr(19'h00105, 8'h00);
    cyc(PROG + 10);
    wr(19'h000AB, 8'h20);
    wr(19'h000AB, 8'hD0);
    rd_exp(19'h00005, 8'h00, 8'h80, "R7 erase polling bit7");
    cyc(150);
    rd_exp(19'h00005, 8'h00, 8'h80, "R5 erase still busy");
    cyc(60);
    rd_exp(19'h00005, 8'hFF, 8'hFF, "R5 R11 sector erased");
    rd_exp(19'h00010, 8'hFF, 8'hFF, "R11 sector erased 010");
    rd_exp(19'h00105, 8'h00, 8'hFF, "R11 other sector kept");
    rd_exp(19'h40105, 8'h00, 8'hFF, "R11 high address alias");

    // R9: lock on, program and erase dropped
    seq_reads(1'b0, 1'b0);
    wr(19'h00030, 8'h10);
    wr(19'h00030, 8'h00);
    rd_exp(19'h00030, 8'hFF, 8'hFF, "R9 locked program not busy");
    cyc(PROG + 10);
    rd_exp(19'h00030, 8'hFF, 8'hFF, "R9 locked program dropped");
    wr(19'h001C0, 8'h20);
    wr(19'h001C0, 8'hD0);
    rd_exp(19'h00105, 8'h00, 8'hFF, "R9 locked erase dropped");

    // R10: broken off-sequence keeps lock
    seq_reads(1'b1, 1'b1);
    wr(19'h00031, 8'h10);
    wr(19'h00031, 8'h00);
    cyc(PROG + 10);
    rd_exp(19'h00031, 8'hFF, 8'hFF, "R10 broken sequence ignored");
    seq_reads(1'b1, 1'b0);
    wr(19'h00031, 8'h10);
    wr(19'h00031, 8'h5A);
    cyc(PROG + 10);
    rd_exp(19'h00031, 8'h5A, 8'hFF, "R9 unlock restores program");
    cyc(10);
    chk(sb_q.size() == 0, "R1 scoreboard drained", sb_q.size(), 0);
    finish_run();
  end
endmodule